// File: doc/BRIEF.md
# Controller Reset and Clock Enable Sequencer

This block brings a serial-link controller and its PHY out of reset in a fixed, timed order after a single start pulse. It first puts everything into a safe state: PHY test power-down on, reference clock off and, where the variant has one, the software core reset held. If the link was still running when the block came out of its own reset, it first rewrites the link-control register through a read-modify-write port. That write clears the 6-bit link-state field and sets the force bit, which drives the link state machine back to detect. It then turns off link training before doing anything else.

The release phase turns on the PHY, bus and core clock enables one after another. It then lifts PHY power-down and waits a settling gap before it turns on the reference clock, so that the reset synchronised inside the PHY lasts long enough. After a further clock-stabilisation wait it drives an endpoint reset pulse of programmable length at a selectable polarity. Last of all it releases the core reset and waits once more before it reports completion. All waits are counted in microsecond ticks from a prescaler on the block clock. A shutdown pulse runs only the safe-state phase and leaves the link down with the reference clock off.

Top module: `link_pwrup_seq`

## Requirements
- R1: On start or shutdown from idle, PHY power-down (phy_pd_o) rises before any clock enable rises. The reference-clock enable falls one cycle after PHY power-down rises. When cfg_sw_rst_i is 1, core_rst_o rises no later than phy_pd_o.
- R2: A start or shutdown taken while both refclk_en_o and ltssm_en_o are 1 produces exactly one lnk_we_o pulse. Its lnk_wdata_o equals lnk_rdata_i with bits 21:16 cleared and bit 15 set. ltssm_en_o falls in the next cycle. In every other case no write is issued. After reset, refclk_en_o and ltssm_en_o take the values of boot_refclk_i and boot_ltssm_i.
- R3: The clock enables rise in the order clk_phy_en_o, clk_bus_en_o, clk_core_en_o, each one cycle after the one before.
- R4: refclk_en_o rises between GAP_US*CLK_PER_US and GAP_US*CLK_PER_US+3 cycles after phy_pd_o falls, and never while phy_pd_o is 1.
- R5: The endpoint reset becomes active between SETTLE_US*CLK_PER_US and that value plus 3 cycles after refclk_en_o rises.
- R6: The endpoint reset stays active for between EPRST_US*CLK_PER_US and that value plus 3 cycles. ep_rst_o equals cfg_ep_act_hi_i while active and its inverse otherwise, including in idle and after reset.
- R7: With cfg_sw_rst_i=1, core_rst_o falls after the endpoint reset ends, and done_o follows between POST_US*CLK_PER_US and that value plus 3 cycles later. With cfg_sw_rst_i=0, core_rst_o never rises and done_o follows the end of the endpoint pulse within 2 cycles.
- R8: done_o is a single-cycle pulse at the end of a start sequence. busy_o is 1 from the cycle after the start is taken until done_o, and 0 when done_o is 1.
- R9: A shutdown pulse leaves phy_pd_o at 1, refclk_en_o at 0 and the clock enables unchanged. It returns to idle with no done_o pulse.
- R10: start_i and shutdown_i pulses are ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_refclk_i | input | 1 | Reference-clock enable state left by earlier firmware, loaded at reset |
| boot_ltssm_i | input | 1 | Link-training enable state left by earlier firmware, loaded at reset |
| cfg_sw_rst_i | input | 1 | 1: variant has a software core reset to hold and release |
| cfg_ep_act_hi_i | input | 1 | Endpoint reset active level (1 = active-high) |
| start_i | input | 1 | Pulse: run full power-up sequence |
| shutdown_i | input | 1 | Pulse: run only the safe-state phase (wins over start_i) |
| lnk_rdata_i | input | 32 | Current link-control register value |
| lnk_wdata_o | output | 32 | Link-control write value |
| lnk_we_o | output | 1 | Link-control write strobe |
| ltssm_en_o | output | 1 | Link training enable |
| refclk_en_o | output | 1 | Reference clock enable |
| phy_pd_o | output | 1 | PHY test power-down |
| core_rst_o | output | 1 | Software core reset, active high |
| clk_phy_en_o | output | 1 | PHY clock enable |
| clk_bus_en_o | output | 1 | Bus clock enable |
| clk_core_en_o | output | 1 | Core clock enable |
| ep_rst_o | output | 1 | Endpoint reset, level set by cfg_ep_act_hi_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The branch that is hardest to reach is the one that recovers a link left running. The block's own sequences never leave link training enabled, so that state cannot come from start or shutdown pulses alone. The bench gets there by driving boot_refclk_i and boot_ltssm_i high while rst_n is low. It then checks the single masked write, the drop of training enable and the ordering of the power-down steps that follow. A second case with only the reference clock left on confirms that the write is skipped.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
    localparam int LNK_W     = 32;
    localparam int LS_LSB    = 16;
    localparam int LS_W      = 6;
    localparam int FORCE_BIT = 15;

    typedef enum logic [3:0] {
        S_IDLE, S_FORCE, S_LTSSM_OFF, S_ASRT_PD, S_RCLK_OFF,
        S_CK_PHY, S_CK_BUS, S_CK_CORE, S_PD_OFF,
        S_GAP, S_SETTLE, S_EP_HOLD, S_RELEASE, S_POST
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic             shut;
        logic             core_rst;
        logic             phy_pd;
        logic             refclk;
        logic             ltssm;
        logic             ck_phy;
        logic             ck_bus;
        logic             ck_core;
        logic             ep_act;
        logic             done;
        logic             we;
        logic [LNK_W-1:0] wdata;
    } seq_regs_t;
endpackage

// File: rtl/pwrup_us_timer.sv
module pwrup_us_timer #(
    parameter int CLK_PER_US = 100,
    parameter int CW         = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          exp_o
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

    typedef struct packed {
        logic          run;
        logic          exp;
        logic [PW-1:0] pre;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.exp = 1'b0;
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.pre = '0;
            tmr_d.cnt = len_i;
        end else if (tmr_q.run) begin
            if (tmr_q.pre == PRE_LAST) begin
                tmr_d.pre = '0;
                if (tmr_q.cnt <= CW'(1)) begin
                    tmr_d.run = 1'b0;
                    tmr_d.exp = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt - CW'(1);
                end
            end else begin
                tmr_d.pre = tmr_q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign exp_o = tmr_q.exp;

    // R5
    exp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.exp |=> !tmr_q.exp);
    // R4
    exp_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.exp) |-> $past(tmr_q.run));
endmodule

// File: rtl/pwrup_linkfix.sv
module pwrup_linkfix
    import pwrup_pkg::*;
(
    input  logic [LNK_W-1:0] rd_i,
    output logic [LNK_W-1:0] wd_o
);
    for (genvar i = 0; i < LNK_W; i++) begin : g_bit
        if (i == FORCE_BIT) begin : g_force
            assign wd_o[i] = 1'b1;
        end else if (i >= LS_LSB && i < LS_LSB + LS_W) begin : g_clear
            assign wd_o[i] = 1'b0;
        end else begin : g_keep
            assign wd_o[i] = rd_i[i];
        end
    end
endmodule

// File: rtl/link_pwrup_seq.sv
module link_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int GAP_US     = 10,
    parameter int SETTLE_US  = 200,
    parameter int EPRST_US   = 100000,
    parameter int POST_US    = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_refclk_i,
    input  logic             boot_ltssm_i,
    input  logic             cfg_sw_rst_i,
    input  logic             cfg_ep_act_hi_i,
    input  logic             start_i,
    input  logic             shutdown_i,
    input  logic [LNK_W-1:0] lnk_rdata_i,
    output logic [LNK_W-1:0] lnk_wdata_o,
    output logic             lnk_we_o,
    output logic             ltssm_en_o,
    output logic             refclk_en_o,
    output logic             phy_pd_o,
    output logic             core_rst_o,
    output logic             clk_phy_en_o,
    output logic             clk_bus_en_o,
    output logic             clk_core_en_o,
    output logic             ep_rst_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int MAX_A  = (GAP_US > SETTLE_US) ? GAP_US : SETTLE_US;
    localparam int MAX_B  = (EPRST_US > POST_US) ? EPRST_US : POST_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_US + 1);

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CW-1:0]    tmr_len;
    logic             tmr_exp;
    logic [LNK_W-1:0] fix_wd;
    logic             link_left_on;

    pwrup_linkfix i_fix (
        .rd_i (lnk_rdata_i),
        .wd_o (fix_wd)
    );

    pwrup_us_timer #(.CLK_PER_US(CLK_PER_US), .CW(CW)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .exp_o  (tmr_exp)
    );

    assign link_left_on = r_q.refclk && r_q.ltssm;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.we   = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (shutdown_i || start_i) begin
                    r_d.shut = shutdown_i;
                    r_d.st   = link_left_on ? S_FORCE : S_ASRT_PD;
                end
            end
            S_FORCE: begin
                r_d.we    = 1'b1;
                r_d.wdata = fix_wd;
                r_d.st    = S_LTSSM_OFF;
            end
            S_LTSSM_OFF: begin
                r_d.ltssm = 1'b0;
                r_d.st    = S_ASRT_PD;
            end
            S_ASRT_PD: begin
                r_d.phy_pd   = 1'b1;
                r_d.core_rst = cfg_sw_rst_i;
                r_d.st       = S_RCLK_OFF;
            end
            S_RCLK_OFF: begin
                r_d.refclk = 1'b0;
                r_d.st     = r_q.shut ? S_IDLE : S_CK_PHY;
            end
            S_CK_PHY: begin
                r_d.ck_phy = 1'b1;
                r_d.st     = S_CK_BUS;
            end
            S_CK_BUS: begin
                r_d.ck_bus = 1'b1;
                r_d.st     = S_CK_CORE;
            end
            S_CK_CORE: begin
                r_d.ck_core = 1'b1;
                r_d.st      = S_PD_OFF;
            end
            S_PD_OFF: begin
                r_d.phy_pd = 1'b0;
                r_d.st     = S_GAP;
            end
            S_GAP: begin
                if (tmr_exp) begin
                    r_d.refclk = 1'b1;
                    r_d.st     = S_SETTLE;
                end
            end
            S_SETTLE: begin
                if (tmr_exp) begin
                    r_d.ep_act = 1'b1;
                    r_d.st     = S_EP_HOLD;
                end
            end
            S_EP_HOLD: begin
                if (tmr_exp) begin
                    r_d.ep_act = 1'b0;
                    r_d.st     = S_RELEASE;
                end
            end
            S_RELEASE: begin
                if (cfg_sw_rst_i) begin
                    r_d.core_rst = 1'b0;
                    r_d.st       = S_POST;
                end else begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            S_POST: begin
                if (tmr_exp) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (r_d.st != r_q.st) &&
                   (r_d.st inside {S_GAP, S_SETTLE, S_EP_HOLD, S_POST});
        unique case (r_d.st)
            S_GAP:     tmr_len = CW'(GAP_US);
            S_SETTLE:  tmr_len = CW'(SETTLE_US);
            S_EP_HOLD: tmr_len = CW'(EPRST_US);
            default:   tmr_len = CW'(POST_US);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
            r_q.refclk <= boot_refclk_i;
            r_q.ltssm  <= boot_ltssm_i;
        end else begin
            r_q <= r_d;
        end
    end

    assign lnk_wdata_o   = r_q.wdata;
    assign lnk_we_o      = r_q.we;
    assign ltssm_en_o    = r_q.ltssm;
    assign refclk_en_o   = r_q.refclk;
    assign phy_pd_o      = r_q.phy_pd;
    assign core_rst_o    = r_q.core_rst;
    assign clk_phy_en_o  = r_q.ck_phy;
    assign clk_bus_en_o  = r_q.ck_bus;
    assign clk_core_en_o = r_q.ck_core;
    assign ep_rst_o      = r_q.ep_act ? cfg_ep_act_hi_i : !cfg_ep_act_hi_i;
    assign busy_o        = (r_q.st != S_IDLE);
    assign done_o        = r_q.done;

    // R2
    force_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_we_o |-> ltssm_en_o && refclk_en_o);
    // R2
    ltssm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_we_o |=> !ltssm_en_o);
    // R3
    bus_after_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_bus_en_o) |-> clk_phy_en_o);
    // R3
    core_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_core_en_o) |-> clk_bus_en_o);
    // R4
    refclk_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refclk_en_o) |-> !phy_pd_o);
    // R6
    ep_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ep_act |-> refclk_en_o && clk_core_en_o && !phy_pd_o);
    // R7
    core_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> !r_q.ep_act && clk_core_en_o);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && refclk_en_o && !phy_pd_o);
endmodule

// File: tb/test_link_pwrup_seq.sv
module test_link_pwrup_seq;
    localparam int P    = 2;
    localparam int GAP  = 3;
    localparam int SET  = 5;
    localparam int EPR  = 20;
    localparam int POST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_refclk = 1'b0, boot_ltssm = 1'b0;
    logic        sw_rst = 1'b1, pol = 1'b1;
    logic        start = 1'b0, shut = 1'b0;
    logic [31:0] rdata = 32'h00AA_55AA;
    logic [31:0] wdata;
    logic we, ltssm, refclk, pd, core_rst, ckp, ckb, ckc, ep, busy, done;

    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    link_pwrup_seq #(.CLK_PER_US(P), .GAP_US(GAP), .SETTLE_US(SET),
                     .EPRST_US(EPR), .POST_US(POST)) i_link_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .boot_refclk_i(boot_refclk),
        .boot_ltssm_i(boot_ltssm), .cfg_sw_rst_i(sw_rst),
        .cfg_ep_act_hi_i(pol), .start_i(start), .shutdown_i(shut),
        .lnk_rdata_i(rdata), .lnk_wdata_o(wdata), .lnk_we_o(we),
        .ltssm_en_o(ltssm), .refclk_en_o(refclk), .phy_pd_o(pd),
        .core_rst_o(core_rst), .clk_phy_en_o(ckp), .clk_bus_en_o(ckb),
        .clk_core_en_o(ckc), .ep_rst_o(ep), .busy_o(busy), .done_o(done));

    // edge monitor, sampled away from the active edge
    logic p_pd = 0, p_ref = 0, p_ltssm = 0, p_core = 0, p_ckp = 0, p_ckb = 0, p_ckc = 0, p_ep = 0;
    int t_pd_rise, t_pd_fall, t_ref_rise, t_ref_fall, t_ltssm_fall, t_core_rise, t_core_fall;
    int t_ckp, t_ckb, t_ckc, t_ep_on, t_ep_off, t_done, t_we;
    int n_done = 0, n_we = 0, n_pd_rise = 0, n_ep_on = 0, n_core_rise = 0;
    logic [31:0] last_wd = '0;
    logic ep_act;
    assign ep_act = (ep == pol);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (pd && !p_pd) begin t_pd_rise <= cyc; n_pd_rise <= n_pd_rise + 1; end
            if (!pd && p_pd) t_pd_fall <= cyc;
            if (refclk && !p_ref) t_ref_rise <= cyc;
            if (!refclk && p_ref) t_ref_fall <= cyc;
            if (!ltssm && p_ltssm) t_ltssm_fall <= cyc;
            if (core_rst && !p_core) begin t_core_rise <= cyc; n_core_rise <= n_core_rise + 1; end
            if (!core_rst && p_core) t_core_fall <= cyc;
            if (ckp && !p_ckp) t_ckp <= cyc;
            if (ckb && !p_ckb) t_ckb <= cyc;
            if (ckc && !p_ckc) t_ckc <= cyc;
            if (ep_act && !p_ep) begin t_ep_on <= cyc; n_ep_on <= n_ep_on + 1; end
            if (!ep_act && p_ep) t_ep_off <= cyc;
            if (done) begin t_done <= cyc; n_done <= n_done + 1; end
            if (we) begin t_we <= cyc; n_we <= n_we + 1; last_wd <= wdata; end
        end
        p_pd <= pd; p_ref <= refclk; p_ltssm <= ltssm; p_core <= core_rst;
        p_ckp <= ckp; p_ckb <= ckb; p_ckc <= ckc; p_ep <= ep_act;
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        chk(act >= lo && act <= hi, req, act, lo);
    endtask

    task automatic do_reset(input logic bref, input logic blt);
        @(negedge clk);
        rst_n = 1'b0; boot_refclk = bref; boot_ltssm = blt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input logic s, input logic sd);
        start = s; shut = sd;
        @(negedge clk);
        start = 1'b0; shut = 1'b0;
    endtask

    task automatic wait_done(input int base);
        while (n_done == base) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset(1'b0, 1'b0);
        chk(!refclk && !ltssm && !pd && !core_rst, "R2 reset enables", {refclk, ltssm, pd, core_rst}, 0);
        chk(!ckp && !ckb && !ckc, "R3 reset clocks", {ckp, ckb, ckc}, 0);
        chk(ep == !pol, "R6 reset ep level", ep, !pol);
        chk(!busy && !done && !we, "R8 reset idle", {busy, done, we}, 0);
    endtask

    task automatic t_full_run(input logic sw, input logic hi);
        int bd, bwe, bpd, bcr;
        sw_rst = sw; pol = hi;
        do_reset(1'b0, 1'b0);
        chk(ep == !hi, "R6 idle level", ep, !hi);
        bd = n_done; bwe = n_we; bpd = n_pd_rise; bcr = n_core_rise;
        pulse(1'b1, 1'b0);
        chk(busy, "R8 busy after start", busy, 1);
        wait_done(bd);
        chk(n_pd_rise - bpd == 1 && t_pd_rise < t_ckp, "R1 pd before clocks", t_pd_rise, t_ckp);
        if (sw) chk(t_core_rise <= t_pd_rise, "R1 core reset held", t_core_rise, t_pd_rise);
        chk(n_we == bwe, "R2 no force write", n_we - bwe, 0);
        chk(t_ckb == t_ckp + 1 && t_ckc == t_ckb + 1, "R3 clock order", t_ckc - t_ckp, 2);
        chk_rng("R4 pd to refclk gap", t_ref_rise - t_pd_fall, GAP*P, GAP*P + 3);
        chk_rng("R5 settle wait", t_ep_on - t_ref_rise, SET*P, SET*P + 3);
        chk_rng("R6 ep pulse width", t_ep_off - t_ep_on, EPR*P, EPR*P + 3);
        chk(ep == !hi, "R6 ep inactive after", ep, !hi);
        if (sw) begin
            chk(t_core_fall > t_ep_off, "R7 core release after ep", t_core_fall, t_ep_off + 1);
            chk_rng("R7 post wait", t_done - t_core_fall, POST*P, POST*P + 3);
        end else begin
            chk(n_core_rise == bcr && !core_rst, "R7 no core reset", n_core_rise - bcr, 0);
            chk_rng("R7 done after ep", t_done - t_ep_off, 0, 2);
        end
        chk(n_done - bd == 1 && !done && !busy, "R8 single done", n_done - bd, 1);
        chk(refclk && !pd && ckc, "R8 final state", {refclk, pd, ckc}, 3'b101);
    endtask

    task automatic t_prior_link;
        int bd, bwe;
        sw_rst = 1'b1; pol = 1'b1;
        do_reset(1'b1, 1'b1);
        chk(refclk && ltssm, "R2 boot state loaded", {refclk, ltssm}, 2'b11);
        bd = n_done; bwe = n_we;
        pulse(1'b1, 1'b0);
        wait_done(bd);
        chk(n_we - bwe == 1, "R2 one force write", n_we - bwe, 1);
        chk(last_wd == 32'h0080_D5AA, "R2 force word", last_wd, 32'h0080_D5AA);
        chk(t_ltssm_fall == t_we + 1 && !ltssm, "R2 ltssm dropped", t_ltssm_fall - t_we, 1);
        chk(t_we < t_pd_rise && t_ref_fall == t_pd_rise + 1, "R1 assert order", t_ref_fall - t_pd_rise, 1);
    endtask

    task automatic t_refclk_only;
        int bd, bwe;
        do_reset(1'b1, 1'b0);
        bd = n_done; bwe = n_we;
        pulse(1'b1, 1'b0);
        wait_done(bd);
        chk(n_we == bwe, "R2 no write without training", n_we - bwe, 0);
    endtask

    task automatic t_shutdown;
        int bd, bwe, bpd;
        sw_rst = 1'b1; pol = 1'b0;
        do_reset(1'b0, 1'b0);
        bd = n_done;
        pulse(1'b1, 1'b0);
        wait_done(bd);
        bd = n_done; bwe = n_we; bpd = n_pd_rise;
        pulse(1'b0, 1'b1);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(pd && n_pd_rise - bpd == 1, "R9 pd set", pd, 1);
        chk(!refclk, "R9 refclk off", refclk, 0);
        chk(core_rst, "R1 core reset on shutdown", core_rst, 1);
        chk(ckp && ckb && ckc, "R9 clocks unchanged", {ckp, ckb, ckc}, 3'b111);
        chk(n_done == bd && n_we == bwe, "R9 no done", n_done - bd, 0);
        chk(ep == 1'b1, "R6 active-low idle level", ep, 1);
    endtask

    task automatic t_ignore_busy;
        int bd, bpd;
        sw_rst = 1'b0; pol = 1'b1;
        do_reset(1'b0, 1'b0);
        bd = n_done; bpd = n_pd_rise;
        pulse(1'b1, 1'b0);
        while (!ep_act) @(negedge clk);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        wait_done(bd);
        repeat (12) @(negedge clk);
        chk(n_done - bd == 1, "R10 one done", n_done - bd, 1);
        chk(n_pd_rise - bpd == 1 && !pd, "R10 no rerun", n_pd_rise - bpd, 1);
        chk(refclk && !busy, "R10 refclk kept", {refclk, busy}, 2'b10);
    endtask

    initial begin
        t_reset_state();
        t_full_run(1'b1, 1'b1);
        t_full_run(1'b0, 1'b0);
        t_prior_link();
        t_refclk_only();
        t_shutdown();
        t_ignore_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule